// File: doc/BRIEF.md
# Dual-Domain Power-State Sequencer

This block sequences the power state of two analog domains, a PHY and a PLL, under the control of one 32-bit control word. Software writes a 2-bit requested state into a domain's command field. The block drives that request to the analog side at once. It then waits until the domain either reports ready or a shared settle counter expires. Only then does it copy the request into the domain's status field. Software polls the status field to learn when the transition has finished.

Each domain runs its own transition, and both domains can be in flight at the same time. A new request that arrives during a transition restarts it toward the newest value. Whenever a status field updates, the block raises a one-cycle pulse for that domain. The settle limit is a field in the same control word, so software can trade waiting time against how far it trusts the ready inputs.

Top module: `dual_pwr_seq`

## Requirements
- R1: After reset, both command fields and both status fields read 0 (off), the settle limit reads all ones, both drive outputs are 0 and neither pulse is high.
- R2: The control word reads as follows. Bits 7:6 hold the PHY command and bits 5:4 the PHY status. Bits 3:2 hold the PLL command and bits 1:0 the PLL status. Bits 8+SETTLE_W-1:8 hold the settle limit, which a write stores. Every other bit reads 0 whatever was written to it.
- R3: After a write whose command differs from the domain's status, the status keeps its old value until the transition completes.
- R4: With ready low, a transition completes on the clock edge L+1 edges after the write edge, where L is the settle limit. The limit is compared against the elapsed count on every cycle. If the limit is lowered below the elapsed count, the transition completes on the next edge.
- R5: A high ready input, sampled on an edge after the write edge while the domain is pending, completes the transition on that edge. A high ready input has no effect while the domain is idle.
- R6: On completion, the status field takes the value of the command field.
- R7: The status bits are read-only, and the values written to them are ignored.
- R8: A write of a different command during a transition restarts the count toward the newest value, and the older request never reaches the status field. A write of a command equal to the current status cancels the pending transition and leaves the status unchanged.
- R9: Each domain has a pulse output. It is high for exactly one cycle, in the cycle in which that domain's status field shows a new value, and at no other time.
- R10: Each domain's drive output equals its command field from the cycle after the write.
- R11: A write that leaves a domain's command field unchanged does not restart or delay that domain's pending transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| phy_ready | input | 1 | PHY domain reports settled |
| pll_ready | input | 1 | PLL domain reports settled |
| phy_pwr | output | 2 | Requested power state driven to the PHY |
| pll_pwr | output | 2 | Requested power state driven to the PLL |
| phy_chg | output | 1 | One-cycle pulse when the PHY status updates |
| pll_chg | output | 1 | One-cycle pulse when the PLL status updates |

## Verification
The bench builds the block with SETTLE_W = 4, so the largest settle limit is 15. This keeps the full-length timeout, the zero-limit case and the reset value of the limit within a few dozen cycles. With this width, bits 15:12 of the limit byte lie outside the field, so a write of ones there also exercises the rule that unused bits read 0. The bench also lowers the limit in the middle of a long wait, which reaches the case where the elapsed count already exceeds the new limit.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int NDOM    = 2;
    localparam int DOM_PHY = 0;
    localparam int DOM_PLL = 1;
    localparam int LIM_LSB = 8;

    typedef logic [1:0] pwr_code_t;

    localparam pwr_code_t PWR_OFF = 2'd0;

    // command field position; the status field sits directly below it
    function automatic int cmd_lsb(input int dom);
        return (dom == DOM_PHY) ? 6 : 2;
    endfunction

    function automatic int sts_lsb(input int dom);
        return cmd_lsb(dom) - 2;
    endfunction

endpackage

// File: rtl/dps_domain.sv
module dps_domain
    import dps_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  pwr_code_t           wr_cmd,
    input  logic [SETTLE_W-1:0] settle_lim,
    input  logic                ready_in,
    output pwr_code_t           cmd_out,
    output pwr_code_t           sts_out,
    output logic                chg_out
);

    typedef struct packed {
        pwr_code_t           cmd;
        pwr_code_t           sts;
        logic                busy;
        logic [SETTLE_W-1:0] cnt;
        logic                chg;
    } dom_state_t;

    dom_state_t st_d, st_q;

    logic cmd_new;
    logic settled;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        cmd_new  = wr_en && (wr_cmd != st_q.cmd);
        // >= so that lowering the limit mid-wait cannot wrap the counter
        settled  = ready_in || (st_q.cnt >= settle_lim);

        if (cmd_new) begin
            st_d.cmd  = wr_cmd;
            st_d.busy = (wr_cmd != st_q.sts);
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (settled) begin
                st_d.sts  = st_q.cmd;
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.chg  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cmd: PWR_OFF, sts: PWR_OFF, busy: 1'b0, cnt: '0, chg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_out = st_q.cmd;
    assign sts_out = st_q.sts;
    assign chg_out = st_q.chg;

endmodule

// File: rtl/dps_ctrl_reg.sv
module dps_ctrl_reg
    import dps_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SETTLE_W-1:0]        lim_wr,
    input  logic [NDOM-1:0][1:0]       cmd_in,
    input  logic [NDOM-1:0][1:0]       sts_in,
    output logic [SETTLE_W-1:0]        lim_out,
    output logic [31:0]                rd_word
);

    typedef struct packed {
        logic [SETTLE_W-1:0] lim;
    } reg_state_t;

    reg_state_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (wr_en) begin
            rs_d.lim = lim_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '{lim: '1};
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        rd_word = '0;
        rd_word[LIM_LSB +: SETTLE_W] = rs_q.lim;
        for (int d = 0; d < NDOM; d++) begin
            rd_word[cmd_lsb(d) +: 2] = cmd_in[d];
            rd_word[sts_lsb(d) +: 2] = sts_in[d];
        end
    end

    assign lim_out = rs_q.lim;

endmodule

// File: rtl/dual_pwr_seq.sv
module dual_pwr_seq
    import dps_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        phy_ready,
    input  logic        pll_ready,
    output logic [1:0]  phy_pwr,
    output logic [1:0]  pll_pwr,
    output logic        phy_chg,
    output logic        pll_chg
);

    logic [NDOM-1:0][1:0] cmd_w;
    logic [NDOM-1:0][1:0] sts_w;
    logic [NDOM-1:0]      chg_w;
    logic [NDOM-1:0]      rdy_w;
    logic [SETTLE_W-1:0]  lim_w;

    assign rdy_w[DOM_PHY] = phy_ready;
    assign rdy_w[DOM_PLL] = pll_ready;

    dps_ctrl_reg #(.SETTLE_W(SETTLE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .lim_wr  (wr_data[LIM_LSB +: SETTLE_W]),
        .cmd_in  (cmd_w),
        .sts_in  (sts_w),
        .lim_out (lim_w),
        .rd_word (rd_data)
    );

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        dps_domain #(.SETTLE_W(SETTLE_W)) u_dom (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .wr_cmd     (wr_data[cmd_lsb(d) +: 2]),
            .settle_lim (lim_w),
            .ready_in   (rdy_w[d]),
            .cmd_out    (cmd_w[d]),
            .sts_out    (sts_w[d]),
            .chg_out    (chg_w[d])
        );
    end

    assign phy_pwr = cmd_w[DOM_PHY];
    assign pll_pwr = cmd_w[DOM_PLL];
    assign phy_chg = chg_w[DOM_PHY];
    assign pll_chg = chg_w[DOM_PLL];

endmodule

// File: rtl/dual_pwr_seq_chk.sv
module dual_pwr_seq_chk
    import dps_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        phy_chg,
    input logic        pll_chg
);

    logic [NDOM-1:0] chg;
    assign chg[DOM_PHY] = phy_chg;
    assign chg[DOM_PLL] = pll_chg;

    assert_lim_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[LIM_LSB +: SETTLE_W] == $past(wr_data[LIM_LSB +: SETTLE_W]));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[31:16] != '0)) |=> rd_data[31:16] == '0);

    for (genvar d = 0; d < NDOM; d++) begin : g_chk
        localparam int CL = cmd_lsb(d);
        localparam int SL = sts_lsb(d);

        assert_sts_moves_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(rd_data[SL +: 2]) |-> chg[d]);

        assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
            chg[d] |=> !chg[d]);

        assert_pulse_matches_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
            chg[d] |-> rd_data[SL +: 2] == rd_data[CL +: 2]);

        assert_new_cmd_holds_sts_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[CL +: 2] != rd_data[CL +: 2]) |=> $stable(rd_data[SL +: 2]));

        assert_idle_sts_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[CL +: 2] == rd_data[CL +: 2]
                   && rd_data[CL +: 2] == rd_data[SL +: 2]
                   && wr_data[SL +: 2] != rd_data[SL +: 2]) |=> $stable(rd_data[SL +: 2]));
    end

endmodule

bind dual_pwr_seq dual_pwr_seq_chk #(.SETTLE_W(SETTLE_W)) u_chk (.*);

// File: tb/dual_pwr_seq_test.sv
module dual_pwr_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        phy_ready = 1'b0;
    logic        pll_ready = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  phy_pwr, pll_pwr;
    logic        phy_chg, pll_chg;

    dual_pwr_seq #(.SETTLE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .phy_ready(phy_ready), .pll_ready(pll_ready),
        .phy_pwr(phy_pwr), .pll_pwr(pll_pwr), .phy_chg(phy_chg), .pll_chg(pll_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         dom;
        logic [1:0] val;
        int         at;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;

    function automatic void check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // driver: one-cycle write, returns the bench cycle at the driving negedge
    task automatic wr_raw(input logic [31:0] w, output int c);
        wr_data = w;
        wr_en   = 1'b1;
        c       = cyc;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wr(input logic [1:0] phy, input logic [1:0] pll, input int lim, output int c);
        wr_raw({16'h0, 8'(lim), phy, 2'b00, pll, 2'b00}, c);
    endtask

    task automatic expect_chg(input int dom, input logic [1:0] val, input int at);
        sb.push_back('{dom: dom, val: val, at: at});
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: every status pulse must match a scoreboard item
    always @(negedge clk) begin
        if (mon_on) begin
            for (int d = 0; d < 2; d++) begin
                logic       p;
                logic [1:0] s;
                int         idx;
                p   = (d == 0) ? phy_chg : pll_chg;
                s   = (d == 0) ? rd_data[5:4] : rd_data[1:0];
                idx = -1;
                if (p) begin
                    foreach (sb[i]) if (idx < 0 && sb[i].dom == d) idx = i;
                    if (idx < 0) begin
                        check_eq("R9", $sformatf("unexpected pulse dom %0d", d), 1, 0);
                    end else begin
                        check_eq("R9", $sformatf("pulse cycle dom %0d", d), cyc, sb[idx].at);
                        check_eq("R6", $sformatf("status value dom %0d", d), s, sb[idx].val);
                        sb.delete(idx);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int c, c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_eq("R1", "reset word", rd_data, 32'h0000_0F00);
        check_eq("R1", "reset phy drive", phy_pwr, 0);
        check_eq("R1", "reset pll drive", pll_pwr, 0);
        check_eq("R1", "reset pulses", {phy_chg, pll_chg}, 0);
        mon_on = 1'b1;

        // R3 R4 R10 R11: timeout path, rewrite of the same command mid-wait
        wr(2'd2, 2'd0, 5, c);
        expect_chg(0, 2'd2, c + 7);
        check_eq("R10", "phy drive after write", phy_pwr, 2);
        check_eq("R3", "phy status lags", rd_data[5:4], 0);
        wait_until(c + 3);
        wr(2'd2, 2'd0, 5, c2);
        check_eq("R3", "phy status still old", rd_data[5:4], 0);
        wait_until(c + 8);
        check_eq("R4", "phy status after timeout", rd_data[5:4], 2);

        // R5: ready while idle does nothing, ready while pending completes
        phy_ready = 1'b1; pll_ready = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R5", "idle ready ignored", rd_data[7:0], 8'h A0);
        phy_ready = 1'b0; pll_ready = 1'b0;
        wr(2'd2, 2'd3, 5, c);
        expect_chg(1, 2'd3, c + 4);
        wait_until(c + 3);
        pll_ready = 1'b1;
        @(negedge clk);
        pll_ready = 1'b0;
        wait_until(c + 6);
        check_eq("R5", "pll status after ready", rd_data[1:0], 3);

        // R8: restart toward newest command
        wr(2'd1, 2'd3, 6, c);
        wait_until(c + 4);
        wr(2'd3, 2'd3, 6, c2);
        expect_chg(0, 2'd3, c2 + 8);
        wait_until(c + 9);
        check_eq("R8", "older request not reached", rd_data[5:4], 2);
        wait_until(c2 + 10);
        check_eq("R8", "newest request reached", rd_data[5:4], 3);

        // R8 cancel: write back the current status
        wr(2'd0, 2'd3, 6, c);
        wait_until(c + 3);
        wr(2'd3, 2'd3, 6, c2);
        wait_until(c2 + 12);
        check_eq("R8", "cancel keeps status", rd_data[5:4], 3);
        check_eq("R10", "drive after cancel", phy_pwr, 3);

        // R7 R2: status bits and unused bits ignored on write
        wr_raw(32'hFFFF_F6CD, c);
        check_eq("R7", "read-only status word", rd_data, 32'h0000_06FF);
        repeat (4) @(negedge clk);
        check_eq("R7", "status unchanged later", rd_data, 32'h0000_06FF);

        // R4 zero limit, both domains together
        wr(2'd1, 2'd2, 0, c);
        expect_chg(0, 2'd1, c + 2);
        expect_chg(1, 2'd2, c + 2);
        wait_until(c + 4);
        check_eq("R2", "word after zero limit", rd_data, 32'h0000_005A);

        // R4 limit lowered below elapsed count
        wr(2'd2, 2'd0, 15, c);
        expect_chg(0, 2'd2, c + 11);
        expect_chg(1, 2'd0, c + 11);
        wait_until(c + 9);
        wr(2'd2, 2'd0, 3, c2);
        wait_until(c + 13);
        check_eq("R4", "lowered limit", rd_data[7:0], 8'h A0);

        // R4 maximum limit
        wr(2'd0, 2'd3, 15, c);
        expect_chg(0, 2'd0, c + 17);
        expect_chg(1, 2'd3, c + 17);
        wait_until(c + 19);
        check_eq("R4", "max limit word", rd_data, 32'h0000_0F0F);

        repeat (5) @(negedge clk);
        check_eq("R9", "missing pulses", sb.size(), 0);
        report();
        $finish;
    end

endmodule